// File: doc/BRIEF.md
# Two-Colour Pattern Fill Generator

This block supplies the colour of each pixel in a patterned fill. Software loads a 64-bit monochrome pattern, split across two 32-bit words, together with two colour values and a shape code. The shape code sets how the 64 pattern bits are laid over the screen: as a square tile eight pixels on a side, as a strip one row high and 64 pixels wide, or as a strip one column wide and 64 pixels high. Each pattern repeats in both directions across the whole coordinate space.

A drawing engine presents screen coordinates on the query port. The block reduces them to a pattern bit index according to the shape and picks the first colour for a clear bit or the second colour for a set bit. A parameter sets whether the answer is registered, and so appears one cycle after the query, or comes straight from logic in the same cycle. Raster operations, clipping and memory writes happen outside this block.

Top module: `patfill_gen`

## Requirements
- R1: After reset both colours and both pattern words are zero and the shape is the 8x8 tile; px_valid and px_colour are zero.
- R2: A write with wr_en high stores wr_data by wr_sel: 0 shape (wr_data bits 1:0), 1 colour for clear bits, 2 colour for set bits, 3 pattern bits 0..31, 4 pattern bits 32..63 (wr_data bit n is pattern bit n or n+32); wr_sel codes 5, 6 and 7 change nothing.
- R3: A pattern bit of 0 returns the colour for clear bits and a pattern bit of 1 returns the colour for set bits.
- R4: Shape 0 (8x8 tile) uses bit index (y mod 8)*8 + (x mod 8).
- R5: Shape 1 (64 wide, 1 high) uses bit index x mod 64.
- R6: Shape 2 (1 wide, 64 high) uses bit index y mod 64.
- R7: Shape code 3 behaves exactly as shape 0.
- R8: With OUT_REG=1 a query sampled at a clock edge gives px_valid high and its colour right after that edge; px_valid is low after any edge at which q_valid was low.
- R9: A query sampled at the same edge as a register write sees the values held before that write.
- R10: px_colour holds its value across cycles with no query.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Register write data |
| q_valid | input | 1 | Pixel query strobe |
| q_x | input | COORD_W | Query x coordinate |
| q_y | input | COORD_W | Query y coordinate |
| px_valid | output | 1 | Result valid |
| px_colour | output | COLOR_W | Selected colour |

## Verification
A register write lands at the edge it is sampled, while a query result is due right after the edge that samples the query, using the register values from before that edge. The bench drives every input on the falling edge and reads px_valid and px_colour one time unit after the following rising edge, so each check sees the answer to exactly one query. The same-cycle write case is checked by pairing a write and a query on one edge and expecting the old colour, then the new colour on the next query; the hold case is read on several idle cycles.

// File: rtl/patfill_pkg.sv
`timescale 1ns/1ps
package patfill_pkg;
   localparam int PAT_WORD  = 32;
   localparam int PAT_BITS  = 2 * PAT_WORD;
   localparam int IDX_W     = $clog2(PAT_BITS);
   localparam int TILE_LOG  = IDX_W / 2;

   typedef enum logic [1:0] {
      SHP_TILE8 = 2'd0,
      SHP_ROW64 = 2'd1,
      SHP_COL64 = 2'd2,
      SHP_RSVD  = 2'd3
   } shape_e;

   typedef enum logic [2:0] {
      SEL_SHAPE = 3'd0,
      SEL_CLR0  = 3'd1,
      SEL_CLR1  = 3'd2,
      SEL_PLO   = 3'd3,
      SEL_PHI   = 3'd4
   } wsel_e;
endpackage

// File: rtl/patfill_regs.sv
`timescale 1ns/1ps
module patfill_regs
   import patfill_pkg::*;
#(
   parameter int COLOR_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [31:0]         wr_data,
   output shape_e              shape,
   output logic [COLOR_W-1:0]  clr0,
   output logic [COLOR_W-1:0]  clr1,
   output logic [PAT_BITS-1:0] pat
);
   localparam int NWORDS = PAT_BITS / PAT_WORD;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shape <= SHP_TILE8;
         clr0  <= '0;
         clr1  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_SHAPE: shape <= shape_e'(wr_data[1:0]);
            SEL_CLR0:  clr0  <= wr_data[COLOR_W-1:0];
            SEL_CLR1:  clr1  <= wr_data[COLOR_W-1:0];
            default:   ;
         endcase
      end
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [2:0] MY_SEL = 3'(SEL_PLO) + 3'(w);
      always_ff @(posedge clk) begin
         if (!rst_n)
            pat[w*PAT_WORD +: PAT_WORD] <= '0;
         else if (wr_en && wr_sel == MY_SEL)
            pat[w*PAT_WORD +: PAT_WORD] <= wr_data;
      end
   end
endmodule

// File: rtl/patfill_index.sv
`timescale 1ns/1ps
module patfill_index
   import patfill_pkg::*;
#(
   parameter int COORD_W = 16
) (
   input  shape_e             shape,
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   output logic [IDX_W-1:0]   idx
);
   logic unused_hi;
   assign unused_hi = ^{x[COORD_W-1:IDX_W], y[COORD_W-1:IDX_W]};

   always_comb begin
      case (shape)
         SHP_ROW64: idx = x[IDX_W-1:0];
         SHP_COL64: idx = y[IDX_W-1:0];
         default:   idx = {y[TILE_LOG-1:0], x[TILE_LOG-1:0]};
      endcase
   end
endmodule

// File: rtl/patfill_select.sv
`timescale 1ns/1ps
module patfill_select
   import patfill_pkg::*;
#(
   parameter int COLOR_W = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                q_valid,
   input  logic [IDX_W-1:0]    idx,
   input  logic [PAT_BITS-1:0] pat,
   input  logic [COLOR_W-1:0]  clr0,
   input  logic [COLOR_W-1:0]  clr1,
   output logic                px_valid,
   output logic [COLOR_W-1:0]  px_colour
);
   logic               bit_on;
   logic [COLOR_W-1:0] pick;

   assign bit_on = pat[idx];
   assign pick   = bit_on ? clr1 : clr0;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            px_valid  <= 1'b0;
            px_colour <= '0;
         end else begin
            px_valid <= q_valid;
            if (q_valid) px_colour <= pick;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign px_valid   = q_valid;
      assign px_colour  = pick;
   end
endmodule

// File: rtl/patfill_gen.sv
`timescale 1ns/1ps
module patfill_gen
   import patfill_pkg::*;
#(
   parameter int COLOR_W = 32,
   parameter int COORD_W = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_sel,
   input  logic [31:0]        wr_data,
   input  logic               q_valid,
   input  logic [COORD_W-1:0] q_x,
   input  logic [COORD_W-1:0] q_y,
   output logic               px_valid,
   output logic [COLOR_W-1:0] px_colour
);
   if (COLOR_W < 1 || COLOR_W > 32) begin : g_bad_color
      $error("patfill_gen: COLOR_W must lie in 1..32");
   end
   if (COORD_W <= IDX_W) begin : g_bad_coord
      $error("patfill_gen: COORD_W must exceed the pattern index width");
   end

   shape_e              shape;
   logic [COLOR_W-1:0]  clr0, clr1;
   logic [PAT_BITS-1:0] pat;
   logic [IDX_W-1:0]    idx;

   patfill_regs #(.COLOR_W(COLOR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .shape(shape), .clr0(clr0), .clr1(clr1), .pat(pat)
   );

   patfill_index #(.COORD_W(COORD_W)) u_index (
      .shape(shape), .x(q_x), .y(q_y), .idx(idx)
   );

   patfill_select #(.COLOR_W(COLOR_W), .OUT_REG(OUT_REG)) u_select (
      .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .idx(idx), .pat(pat),
      .clr0(clr0), .clr1(clr1), .px_valid(px_valid), .px_colour(px_colour)
   );
endmodule

// File: rtl/patfill_chk.sv
`timescale 1ns/1ps
module patfill_chk #(
   parameter int COLOR_W = 32,
   parameter bit OUT_REG = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [2:0]         wr_sel,
   input logic [31:0]        wr_data,
   input logic               q_valid,
   input logic               px_valid,
   input logic [COLOR_W-1:0] px_colour
);
   logic [COLOR_W-1:0] sh_c0, sh_c1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_c0 <= '0;
         sh_c1 <= '0;
      end else if (wr_en) begin
         if (wr_sel == 3'd1) sh_c0 <= wr_data[COLOR_W-1:0];
         if (wr_sel == 3'd2) sh_c1 <= wr_data[COLOR_W-1:0];
      end
   end

   if (OUT_REG) begin : g_seq
      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         q_valid |=> px_valid);
      // R8
      no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !q_valid |=> !px_valid);
      // R3
      colour_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         px_valid |-> (px_colour == $past(sh_c0) || px_colour == $past(sh_c1)));
      // R10
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !q_valid |=> $stable(px_colour));
   end
endmodule

bind patfill_gen patfill_chk #(.COLOR_W(COLOR_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .q_valid(q_valid), .px_valid(px_valid), .px_colour(px_colour)
);

// File: tb/sim_patfill_gen.sv
`timescale 1ns/1ps
module sim_patfill_gen;
   localparam int CW = 32;
   localparam int XW = 16;
   localparam real HALF = 10.0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [31:0]   wr_data = '0;
   logic          q_valid = 1'b0;
   logic [XW-1:0] q_x = '0, q_y = '0;
   logic          px_valid;
   logic [CW-1:0] px_colour;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [1:0]  m_shape;
   logic [31:0] m_c0, m_c1;
   logic [63:0] m_pat;

   always #(HALF) clk = ~clk;

   patfill_gen #(.COLOR_W(CW), .COORD_W(XW), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .q_valid(q_valid), .q_x(q_x), .q_y(q_y), .px_valid(px_valid), .px_colour(px_colour)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_col(int x, int y);
      int idx;
      case (m_shape)
         2'd1:    idx = x % 64;
         2'd2:    idx = y % 64;
         default: idx = (y % 8) * 8 + (x % 8);
      endcase
      return m_pat[idx] ? m_c1 : m_c0;
   endfunction

   task automatic wr(logic [2:0] sel, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         3'd0: m_shape = d[1:0];
         3'd1: m_c0 = d;
         3'd2: m_c1 = d;
         3'd3: m_pat[31:0] = d;
         3'd4: m_pat[63:32] = d;
         default: ;
      endcase
   endtask

   task automatic query(string req, int x, int y);
      logic [31:0] e;
      @(negedge clk);
      q_valid = 1'b1; q_x = XW'(x); q_y = XW'(y);
      e = expect_col(x, y);
      @(posedge clk);
      #1;
      check(req, 32'(px_valid), 32'd1);
      check(req, px_colour, e);
      @(negedge clk);
      q_valid = 1'b0;
   endtask

   task automatic sweep(string req);
      @(negedge clk);
      for (int y = 0; y < 72; y++) begin
         for (int x = 0; x < 72; x++) begin
            logic [31:0] e;
            @(negedge clk);
            q_valid = 1'b1; q_x = XW'(x); q_y = XW'(y);
            e = expect_col(x, y);
            @(posedge clk);
            #1;
            check(req, px_colour, e);
         end
      end
      @(negedge clk);
      q_valid = 1'b0;
   endtask

   initial begin
      m_shape = 2'd0; m_c0 = '0; m_c1 = '0; m_pat = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1", 32'(px_valid), 32'd0);
      check("R1", px_colour, 32'd0);
      query("R1", 3, 3);
      wr(3'd1, 32'hA1A2A3A4);
      wr(3'd2, 32'hB1B2B3B4);
      query("R1", 5, 6);
      wr(3'd3, 32'h0000_0200);
      // R1 default shape is 8x8: bit 9 is x=1,y=1
      query("R1", 1, 1);
      query("R1", 9, 0);

      // R2 unused select codes change nothing
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      for (int i = 0; i < 16; i++) query("R2", i * 5, i * 3);

      // R3 R4 R5 R6 R7 sweeps over each shape and two patterns
      for (int s = 0; s < 4; s++) begin
         wr(3'd0, 32'(s));
         for (int k = 0; k < 2; k++) begin
            wr(3'd3, k == 0 ? 32'h96C3_A50F : 32'h0000_0001);
            wr(3'd4, k == 0 ? 32'h1E2D_3C4B : 32'h8000_0000);
            case (s)
               0: sweep("R4");
               1: sweep("R5");
               2: sweep("R6");
               default: sweep("R7");
            endcase
         end
      end
      wr(3'd0, 32'd1);
      query("R5", 65535, 7);
      wr(3'd0, 32'd2);
      query("R6", 1, 65535);
      wr(3'd0, 32'd0);
      query("R3", 65535, 65535);

      // R9 write and query at the same edge
      wr(3'd3, 32'h0000_0001);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h5555_0000;
      q_valid = 1'b1; q_x = '0; q_y = '0;
      @(posedge clk);
      #1;
      check("R9", px_colour, m_c1);
      m_c1 = 32'h5555_0000;
      @(negedge clk);
      wr_en = 1'b0; q_valid = 1'b0;
      query("R9", 0, 0);
      check("R9", px_colour, 32'h5555_0000);

      // R8 R10 idle cycles
      @(negedge clk);
      q_x = 16'd1; q_y = 16'd2;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk);
         #1;
         check("R8", 32'(px_valid), 32'd0);
         check("R10", px_colour, 32'h5555_0000);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(2.0 * HALF * 200000.0);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule